// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small bank of byte-wide control and status registers on a simple memory-mapped bus. It holds a configuration register, two auxiliary registers, a diagnostic register, a modem-control register, a system-control register and a power-management register. Every access is treated as a byte access: only the low byte of write data is used, and read data carries the register value in the low byte with the upper bits zero.

A power-fail input, when enabled by a configuration bit, sets a sticky pending flag in the second auxiliary register. A level interrupt output follows that flag, masked by the same enable bit. Software clears the flag through a clear bit in the same register, and cannot set the flag by writing. Certain writes produce one-cycle request pulses for a system shutdown, a system reset and a CPU halt, which external logic acts on.

Reset is selective. The diagnostic and system-control registers keep their contents across reset so that software can find them after a restart.

Top module: `aux_sysctl_regs`

## Requirements
- R1: Only bits 7:0 of the write data are stored. A read returns the selected register in bits 7:0 of the read data with bits 31:8 zero, on the clock edge that samples the read strobe.
- R2: The register is selected by the address ANDed with 0x0FFF0000. The decoded values are: configuration 0x1800000, aux1 0x1900000, aux2 0x1910000, diagnostic 0x1A00000, modem control 0x1B00000, system control 0x1F00000, power management 0xA000000. Other values read as zero, and writes to them change nothing.
- R3: The interrupt output is high exactly when aux2 bit 2 (pending) and configuration bit 3 (enable) are both set. It reflects the state after the edge that commits a write or a power-fail event.
- R4: A clock edge with the power-fail input high sets aux2 bit 2 only if configuration bit 3 is set. Otherwise the input is ignored.
- R5: A write to aux2 never sets bit 2. Writing aux2 with bit 1 set clears bit 2. If a power-fail set and a clear fall on the same edge, the set wins.
- R6: All aux2 bits other than bit 2 store the written value.
- R7: Reset clears configuration, aux1, aux2 (including the pending bit), modem control and power management. It leaves diagnostic and system control unchanged.
- R8: A write to aux2 with bit 0 set gives a one-cycle high pulse on the shutdown request in the cycle after the write edge.
- R9: A write to system control with bit 0 set gives a one-cycle pulse on the system reset request. With bit 0 clear, no pulse is produced.
- R10: Any write to power management gives a one-cycle pulse on the halt request.
- R11: Reads have no side effects. They change no register or pending bit and produce no request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Registered read data |
| pwr_fail | input | 1 | Power-fail indication |
| irq | output | 1 | Power-fail interrupt level |
| shutdown_req | output | 1 | Shutdown request pulse |
| sysreset_req | output | 1 | System reset request pulse |
| halt_req | output | 1 | CPU halt request pulse |

## Verification
Every result is due one edge after its stimulus. Read data, the pending bit, the interrupt level and the request pulses all change on the edge that samples the write, read or power-fail input. The bench drives inputs on falling edges and samples on the next falling edge, right after the committing rising edge. Each pulse is then sampled again one cycle later to confirm it lasted a single cycle. Read results go through a queue and are popped only on the falling edge that follows a rising edge that saw the read strobe.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

    localparam int ADDR_W   = 32;
    localparam int BUS_W    = 32;
    localparam int REG_W    = 8;
    localparam int NUM_SEL  = 8;
    localparam logic [ADDR_W-1:0] SEL_MASK = 32'h0FFF_0000;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CFG  = 3'd1,
        SEL_AUX1 = 3'd2,
        SEL_AUX2 = 3'd3,
        SEL_DIAG = 3'd4,
        SEL_MCTL = 3'd5,
        SEL_SCTL = 3'd6,
        SEL_PMGT = 3'd7
    } reg_sel_e;

    // registers that survive reset, indexed by reg_sel_e
    localparam logic [NUM_SEL-1:0] KEEP_ON_RST = 8'b0101_0000;

    // bit positions that the control logic decodes
    localparam int PF_EN_BIT   = 3;
    localparam int PF_PEND_BIT = 2;
    localparam int PF_CLR_BIT  = 1;
    localparam int SHDN_BIT    = 0;
    localparam int SRST_BIT    = 0;

    typedef struct packed {
        logic             valid;
        reg_sel_e         sel;
        logic [REG_W-1:0] data;
    } wr_cmd_t;

    function automatic logic [ADDR_W-1:0] reg_offset(input int idx);
        case (idx)
            1:       return 32'h0180_0000;
            2:       return 32'h0190_0000;
            3:       return 32'h0191_0000;
            4:       return 32'h01A0_0000;
            5:       return 32'h01B0_0000;
            6:       return 32'h01F0_0000;
            7:       return 32'h0A00_0000;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/aux_sysctl_decode.sv
module aux_sysctl_decode
    import aux_sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [NUM_SEL-1:0] hit_o,
    output reg_sel_e           sel_o
);
    logic [ADDR_W-1:0] masked;
    assign masked = addr_i & SEL_MASK;

    for (genvar i = 1; i < NUM_SEL; i++) begin : g_cmp
        assign hit_o[i] = (masked == reg_offset(i));
    end
    assign hit_o[0] = ~|hit_o[NUM_SEL-1:1];

    always_comb begin
        sel_o = SEL_NONE;
        for (int i = 1; i < NUM_SEL; i++) begin
            if (hit_o[i]) sel_o = reg_sel_e'(i);
        end
    end
endmodule

// File: rtl/aux_sysctl_pf.sv
module aux_sysctl_pf (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fail_i,
    input  logic en_i,
    input  logic clr_i,
    output logic pend_o,
    output logic irq_o
);
    logic pend_q;
    logic set_ev;

    assign set_ev = pwr_fail_i & en_i;

    always_ff @(posedge clk) begin
        if (rst)         pend_q <= 1'b0;
        else if (set_ev) pend_q <= 1'b1;
        else if (clr_i)  pend_q <= 1'b0;
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q & en_i;

    // R5: pending stays set unless cleared
    p_pend_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i) |=> pend_q);
    // R4: no set without an enabled power-fail event
    p_pend_noset_r4: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !(pwr_fail_i && en_i)) |=> !pend_q);
endmodule

// File: rtl/aux_sysctl_req.sv
module aux_sysctl_req
    import aux_sysctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd_i,
    output logic    shutdown_o,
    output logic    sysreset_o,
    output logic    halt_o
);
    logic shdn_q, srst_q, halt_q;
    logic shdn_d, srst_d, halt_d;

    assign shdn_d = cmd_i.valid && cmd_i.sel == SEL_AUX2 && cmd_i.data[SHDN_BIT];
    assign srst_d = cmd_i.valid && cmd_i.sel == SEL_SCTL && cmd_i.data[SRST_BIT];
    assign halt_d = cmd_i.valid && cmd_i.sel == SEL_PMGT;

    always_ff @(posedge clk) begin
        if (rst) begin
            shdn_q <= 1'b0;
            srst_q <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            shdn_q <= shdn_d;
            srst_q <= srst_d;
            halt_q <= halt_d;
        end
    end

    assign shutdown_o = shdn_q;
    assign sysreset_o = srst_q;
    assign halt_o     = halt_q;

    // R8: pulse lasts one cycle without a new request
    p_shdn_single_r8: assert property (@(posedge clk) disable iff (rst)
        (shdn_q && !(cmd_i.valid && cmd_i.sel == SEL_AUX2 && cmd_i.data[SHDN_BIT])) |=> !shdn_q);
    // R10: power-management write yields halt
    p_halt_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.valid && cmd_i.sel == SEL_PMGT) |=> halt_q);
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
    import aux_sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              pwr_fail,
    output logic              irq,
    output logic              shutdown_req,
    output logic              sysreset_req,
    output logic              halt_req
);
    logic [NUM_SEL-1:0] hit;
    reg_sel_e           sel;
    logic [REG_W-1:0]   wbyte;
    logic               unused_hi;
    wr_cmd_t            cmd;
    logic [REG_W-1:0]   regs_q [1:NUM_SEL-1];
    logic [REG_W-1:0]   rd_val;
    logic [BUS_W-1:0]   rdata_q;
    logic               pend, pf_clr;

    assign wbyte     = bus_wdata[REG_W-1:0];
    assign unused_hi = ^bus_wdata[BUS_W-1:REG_W];

    aux_sysctl_decode u_dec (
        .addr_i (bus_addr),
        .hit_o  (hit),
        .sel_o  (sel)
    );

    assign cmd.valid = bus_wr && !hit[0];
    assign cmd.sel   = sel;
    assign cmd.data  = wbyte;

    for (genvar i = 1; i < NUM_SEL; i++) begin : g_reg
        if (KEEP_ON_RST[i]) begin : g_keep
            always_ff @(posedge clk) begin
                if (bus_wr && hit[i]) regs_q[i] <= wbyte;
            end
        end else begin : g_clr
            always_ff @(posedge clk) begin
                if (rst)                  regs_q[i] <= '0;
                else if (bus_wr && hit[i]) regs_q[i] <= wbyte;
            end
        end
    end

    assign pf_clr = bus_wr && hit[SEL_AUX2] && wbyte[PF_CLR_BIT];

    aux_sysctl_pf u_pf (
        .clk        (clk),
        .rst        (rst),
        .pwr_fail_i (pwr_fail),
        .en_i       (regs_q[SEL_CFG][PF_EN_BIT]),
        .clr_i      (pf_clr),
        .pend_o     (pend),
        .irq_o      (irq)
    );

    aux_sysctl_req u_req (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd),
        .shutdown_o (shutdown_req),
        .sysreset_o (sysreset_req),
        .halt_o     (halt_req)
    );

    always_comb begin
        rd_val = '0;
        for (int i = 1; i < NUM_SEL; i++) begin
            if (hit[i]) rd_val = regs_q[i];
        end
        if (hit[SEL_AUX2]) rd_val[PF_PEND_BIT] = pend;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= {{(BUS_W-REG_W){1'b0}}, rd_val};
    end
    assign bus_rdata = rdata_q;

    // R2: at most one register selected
    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit[NUM_SEL-1:1]));
    // R3: clearing the enable drops the interrupt
    p_irq_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit[SEL_CFG] && !wbyte[PF_EN_BIT]) |=> !irq);

    // R7: cleared registers read zero right after reset
    logic rst_d;
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d && !rst) begin
            p_rst_clear_r7: assert (regs_q[SEL_CFG] == '0 && regs_q[SEL_AUX1] == '0 &&
                                    regs_q[SEL_AUX2] == '0 && regs_q[SEL_MCTL] == '0 &&
                                    regs_q[SEL_PMGT] == '0 && !pend)
                else $error("reset left a clearable register nonzero");
        end
    end
endmodule

// File: tb/aux_sysctl_regs_test.sv
module aux_sysctl_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] A_CFG  = 32'h0180_0000;
    localparam logic [31:0] A_AUX1 = 32'h0190_0000;
    localparam logic [31:0] A_AUX2 = 32'h0191_0000;
    localparam logic [31:0] A_DIAG = 32'h01A0_0000;
    localparam logic [31:0] A_MCTL = 32'h01B0_0000;
    localparam logic [31:0] A_SCTL = 32'h01F0_0000;
    localparam logic [31:0] A_PMGT = 32'h0A00_0000;
    localparam logic [31:0] A_NONE = 32'h01C0_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic pwr_fail = 1'b0;
    logic irq, shutdown_req, sysreset_req, halt_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit rd_seen = 1'b0;

    typedef struct { logic [31:0] exp; string tag; } rd_item_t;
    rd_item_t exp_q[$];

    aux_sysctl_regs uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_fail(pwr_fail), .irq(irq),
        .shutdown_req(shutdown_req), .sysreset_req(sysreset_req), .halt_req(halt_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pop expected read data one falling edge after the sampling edge
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            rd_item_t it;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL read without expectation: actual=%h expected=none", bus_rdata);
            end else begin
                it = exp_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pf_event();
        @(negedge clk);
        pwr_fail = 1'b1;
        @(negedge clk);
        pwr_fail = 1'b0;
    endtask

    task automatic pulses(input string tag, input logic s, input logic r, input logic h);
        chk({tag, " shutdown"}, {31'b0, shutdown_req}, {31'b0, s});
        chk({tag, " sysreset"}, {31'b0, sysreset_req}, {31'b0, r});
        chk({tag, " halt"},     {31'b0, halt_req},     {31'b0, h});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7: preload kept and cleared registers, then reset again
        wr(A_DIAG, 32'h0000_00A5);
        wr(A_SCTL, 32'h0000_003C);
        pulses("R9 sysctl bit0 clear", 1'b0, 1'b0, 1'b0);
        wr(A_CFG,  32'h0000_0008);
        wr(A_AUX1, 32'h0000_0011);
        wr(A_AUX2, 32'h0000_00F8);
        wr(A_MCTL, 32'h0000_0022);
        pf_event();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk("R7 irq after reset", {31'b0, irq}, 32'h0);
        pulses("R7 reset state", 1'b0, 1'b0, 1'b0);
        rd(A_CFG,  32'h0, "R7 cfg cleared");
        rd(A_AUX1, 32'h0, "R7 aux1 cleared");
        rd(A_AUX2, 32'h0, "R7 aux2 cleared");
        rd(A_MCTL, 32'h0, "R7 mctl cleared");
        rd(A_PMGT, 32'h0, "R7 pmgt cleared");
        rd(A_DIAG, 32'hA5, "R7 diag kept");
        rd(A_SCTL, 32'h3C, "R7 sysctl kept");

        // R1: wide data, byte storage
        wr(A_CFG, 32'h1234_5677);
        rd(A_CFG, 32'h77, "R1 cfg low byte");
        wr(A_AUX1, 32'hFFFF_FF80);
        rd(A_AUX1, 32'h80, "R1 aux1 upper zero");

        // R2: coarse decode, aliases and unmapped space
        wr(32'h31B0_1234, 32'h5C);
        rd(A_MCTL, 32'h5C, "R2 mctl alias write");
        rd(32'hF190_FFFC, 32'h80, "R2 aux1 alias read");
        wr(A_NONE, 32'hFF);
        rd(A_NONE, 32'h0, "R2 unmapped reads zero");
        rd(A_MCTL, 32'h5C, "R2 unmapped write no effect");
        pulses("R2 unmapped write", 1'b0, 1'b0, 1'b0);

        // R4: power fail ignored while disabled
        wr(A_CFG, 32'h00);
        pf_event();
        chk("R4 irq disabled", {31'b0, irq}, 32'h0);
        rd(A_AUX2, 32'h0, "R4 pending ignored");
        wr(A_CFG, 32'h08);
        chk("R3 enable alone no irq", {31'b0, irq}, 32'h0);
        pf_event();
        chk("R3 irq after event", {31'b0, irq}, 32'h1);
        rd(A_AUX2, 32'h04, "R4 pending set");

        // R5 / R11: sticky, not cleared by read or plain write
        rd(A_AUX2, 32'h04, "R11 read keeps pending");
        wr(A_AUX2, 32'h00);
        rd(A_AUX2, 32'h04, "R5 write keeps pending");
        chk("R5 irq kept", {31'b0, irq}, 32'h1);
        wr(A_CFG, 32'h00);
        chk("R3 mask drops irq", {31'b0, irq}, 32'h0);
        wr(A_CFG, 32'h08);
        chk("R3 unmask raises irq", {31'b0, irq}, 32'h1);
        wr(A_AUX2, 32'h02);
        chk("R5 clear drops irq", {31'b0, irq}, 32'h0);
        rd(A_AUX2, 32'h02, "R5 cleared by bit1");
        wr(A_AUX2, 32'h04);
        rd(A_AUX2, 32'h00, "R5 software cannot set");
        chk("R5 no irq from write", {31'b0, irq}, 32'h0);
        wr(A_AUX2, 32'hF8);
        rd(A_AUX2, 32'hF8, "R6 other bits stored");

        // R5: set wins over clear on the same edge
        @(negedge clk); pwr_fail = 1'b1;
        wr(A_AUX2, 32'h02);
        pwr_fail = 1'b0;
        rd(A_AUX2, 32'h06, "R5 set wins");
        wr(A_AUX2, 32'h02);
        rd(A_AUX2, 32'h02, "R5 clear after set");

        // R8: shutdown pulse
        wr(A_AUX2, 32'h01);
        pulses("R8 shutdown", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        pulses("R8 shutdown single", 1'b0, 1'b0, 1'b0);
        // R9: system reset pulse
        wr(A_SCTL, 32'h01);
        pulses("R9 sysreset", 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        pulses("R9 sysreset single", 1'b0, 1'b0, 1'b0);
        rd(A_SCTL, 32'h01, "R9 sysctl stored");
        // R10: halt pulse
        wr(A_PMGT, 32'h00);
        pulses("R10 halt", 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        pulses("R10 halt single", 1'b0, 1'b0, 1'b0);
        // R11: reads produce no pulses
        rd(A_PMGT, 32'h0, "R11 pmgt read");
        pulses("R11 read pmgt", 1'b0, 1'b0, 1'b0);
        rd(A_SCTL, 32'h01, "R11 sysctl read");
        pulses("R11 read sysctl", 1'b0, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 reads outstanding: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule